// File: doc/BRIEF.md
# Paired-Channel Priority Interrupt Controller

This block collects nine peripheral interrupt lines and turns them into one request toward a processor core. Every line has its own edge selection, pending flag, mask bit and overrun flag. The lines are grouped in pairs, and each pair shares a two-bit priority field. The channel's parity supplies the third, lowest priority bit. Among the unmasked pending channels, the one with the highest level wins. When levels are equal, a fixed chain order decides.

The index of the winning channel appears in the middle bits of a vector register that all channels share. The core acknowledges a channel with a one-cycle pulse that carries the channel index, and that clears the channel's pending flag. A small register port gives software access to the masks, edge selects, pair priority fields, vector base bits and overrun flags.

Each channel is tracked by a four-state machine:
- States: `CH_IDLE` (nothing held), `CH_PEND` (pending), `CH_PEND_OVR` (pending with overrun) and `CH_OVR_HELD` (overrun held, not pending).
- Transitions on an event:
  - `CH_IDLE` to `CH_PEND`.
  - `CH_PEND` to `CH_PEND_OVR`.
  - `CH_OVR_HELD` to `CH_PEND_OVR`.
- Transitions on an acknowledge:
  - `CH_PEND` to `CH_IDLE`.
  - `CH_PEND_OVR` to `CH_OVR_HELD`.
- Transitions on an overrun clear:
  - `CH_PEND_OVR` to `CH_PEND`.
  - `CH_OVR_HELD` to `CH_IDLE`.
- Combined cases:
  - Acknowledge and clear together take `CH_PEND_OVR` to `CH_IDLE`.
  - An event in the same cycle as an acknowledge keeps a channel pending.

Top module: `pair_prio_irq_ctrl`

## Requirements
- R1: After reset the following hold:
  - Pending and overrun flags are 0.
  - All mask bits are 0.
  - All edge selects are 1.
  - All pair fields and the vector base bits are 0.
  - `irq_req` is 0 and the vector reads 0x00.
- R2: An event sets the channel's pending flag at the clock edge where the sampled input differs from its registered copy, and the flag is visible in the following cycle.
  - With edge select 1, the event is a 0-to-1 change; with edge select 0, it is a 1-to-0 change.
- R3: Channel index k (E0=0, E1=1, F0=2, F1=3, G0=4, G1=5, H0=6, H1=7, I0=8) has the level {pair field of pair k/2, k mod 2}.
  - Pair fields sit in register 5: E in bits 1:0, F in bits 3:2, G in bits 5:4, H in bits 7:6.
  - The I field sits in register 4, bits 5:4.
- R4: The unmasked pending channel with the numerically largest level wins.
- R5: Among equal top levels, the lowest channel index wins.
- R6: A channel whose mask bit is 0 raises no request and never wins, but its pending flag is kept.
- R7: `irq_req` is 1 exactly when at least one channel is both pending and unmasked.
- R8: The vector (register 6 and `vector_out`) has this layout:
  - Bits 7:5 hold the software base.
  - Bits 4:1 hold the winner's index, or 0 when there is no winner.
  - Bit 0 is 0.
- R9: An `ack_valid` pulse with `ack_index` k clears the pending flag of channel k one cycle later.
  - An acknowledge for a channel that is not pending, or for an index of 9 or above, changes nothing.
- R10: An event on a channel that is already pending sets its overrun flag. The flag survives an acknowledge, is cleared by writing 0 to its bit, and is not affected by writing 1.
- R11: An event in the same cycle as the acknowledge of that channel leaves the channel pending, with no overrun.
- R12: Register map. Writes to registers 0 and 7 have no effect, and register 7 reads 0.

| Reg | Content | Access |
|---|---|---|
| 0 | pending[7:0] | read only |
| 1 | overrun[7:0] | write 0 to clear |
| 2 | mask[7:0] | read/write |
| 3 | edge select[7:0] | read/write |
| 4 | bit 0 pending[8] (read only), bit 1 overrun[8] (write 0 to clear), bit 2 mask[8], bit 3 edge select[8], bits 5:4 I field | see per bit |
| 5 | pair fields | read/write |
| 6 | vector | bits 7:5 writable |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 9 | Peripheral interrupt lines, index 0 (E0) to 8 (I0) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ack_valid | input | 1 | Acknowledge pulse |
| ack_index | input | 4 | Index of the channel being served |
| irq_req | output | 1 | Request to the core |
| vector_out | output | 8 | Shared vector register value |

## Verification
Edge events, acknowledges and register writes all land in state at the first rising clock edge after they are driven. Pending, overrun, `irq_req` and the vector therefore show the result one cycle after the stimulus. The vector and `irq_req` follow combinationally from that state, and register reads return data in the same cycle as the address. The bench drives every input just after a falling edge and samples just after the next falling edge, so each check falls exactly one register stage after its stimulus.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int N_CH   = 9;
    localparam int IDX_W  = $clog2(N_CH + 1);
    localparam int N_PAIR = (N_CH + 1) / 2;
    localparam int FLD_W  = 2;
    localparam int LVL_W  = FLD_W + 1;
    localparam int DW     = 8;
    localparam int AW     = 3;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_PEND,
        CH_PEND_OVR,
        CH_OVR_HELD
    } ch_state_e;

    typedef enum logic [AW-1:0] {
        A_PEND_LO = 3'd0,
        A_OVR_LO  = 3'd1,
        A_MASK_LO = 3'd2,
        A_EDGE_LO = 3'd3,
        A_HI      = 3'd4,
        A_PRIO    = 3'd5,
        A_VEC     = 3'd6
    } reg_addr_e;
endpackage

// File: rtl/pic_chan.sv
module pic_chan
    import pic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic rise_sel,
    input  logic ack_hit,
    input  logic ovr_clr,
    output logic pend,
    output logic ovr
);
    logic      line_q;
    logic      ev;
    ch_state_e st_q, st_d;

    assign ev = rise_sel ? (line_in & ~line_q) : (~line_in & line_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= 1'b0;
            st_q   <= CH_IDLE;
        end else begin
            line_q <= line_in;
            st_q   <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_IDLE: begin
                if (ev) st_d = CH_PEND;
            end
            CH_PEND: begin
                if (ev && !ack_hit)      st_d = CH_PEND_OVR;
                else if (!ev && ack_hit) st_d = CH_IDLE;
            end
            CH_PEND_OVR: begin
                if (ev)                        st_d = CH_PEND_OVR;
                else if (ack_hit && ovr_clr)   st_d = CH_IDLE;
                else if (ack_hit)              st_d = CH_OVR_HELD;
                else if (ovr_clr)              st_d = CH_PEND;
            end
            CH_OVR_HELD: begin
                if (ev)           st_d = CH_PEND_OVR;
                else if (ovr_clr) st_d = CH_IDLE;
            end
            default: st_d = CH_IDLE;
        endcase
    end

    always_comb begin
        pend = 1'b0;
        ovr  = 1'b0;
        unique case (st_q)
            CH_IDLE:     begin pend = 1'b0; ovr = 1'b0; end
            CH_PEND:     begin pend = 1'b1; ovr = 1'b0; end
            CH_PEND_OVR: begin pend = 1'b1; ovr = 1'b1; end
            CH_OVR_HELD: begin pend = 1'b0; ovr = 1'b1; end
            default:     begin pend = 1'b0; ovr = 1'b0; end
        endcase
    end

    p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> pend);
    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit && !ev && pend) |=> !pend);
    p_ovr_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && pend && !ack_hit) |=> ovr);
    p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !ovr_clr) |=> ovr);
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
    import pic_pkg::*;
(
    input  logic [N_CH-1:0]         req,
    input  logic [N_PAIR*FLD_W-1:0] fields,
    output logic                    any_req,
    output logic [IDX_W-1:0]        win_idx
);
    logic [LVL_W-1:0] lvl [N_CH];

    for (genvar g = 0; g < N_CH; g++) begin : g_lvl
        assign lvl[g] = {fields[(g/2)*FLD_W +: FLD_W], ((g % 2) == 1)};
    end

    always_comb begin
        logic             found;
        logic [LVL_W-1:0] best;
        found   = 1'b0;
        best    = '0;
        win_idx = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (req[i] && (!found || (lvl[i] > best))) begin
                found   = 1'b1;
                best    = lvl[i];
                win_idx = IDX_W'(i);
            end
        end
        any_req = found;
    end
endmodule

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic [AW-1:0]           addr,
    input  logic [DW-1:0]           wdata,
    output logic [DW-1:0]           rdata,
    input  logic [N_CH-1:0]         pend,
    input  logic [N_CH-1:0]         ovr,
    input  logic [DW-1:0]           vector,
    output logic [N_CH-1:0]         mask,
    output logic [N_CH-1:0]         rise_sel,
    output logic [N_PAIR*FLD_W-1:0] fields,
    output logic [2:0]              vec_base,
    output logic [N_CH-1:0]         ovr_clr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask     <= '0;
            rise_sel <= '1;
            fields   <= '0;
            vec_base <= '0;
        end else if (wr) begin
            unique case (addr)
                A_MASK_LO: mask[7:0]     <= wdata;
                A_EDGE_LO: rise_sel[7:0] <= wdata;
                A_HI: begin
                    mask[8]     <= wdata[2];
                    rise_sel[8] <= wdata[3];
                    fields[9:8] <= wdata[5:4];
                end
                A_PRIO: fields[7:0] <= wdata;
                A_VEC:  vec_base    <= wdata[7:5];
                default: ;
            endcase
        end
    end

    always_comb begin
        ovr_clr = '0;
        if (wr && addr == A_OVR_LO) ovr_clr[7:0] = ~wdata;
        if (wr && addr == A_HI)     ovr_clr[8]   = ~wdata[1];
    end

    always_comb begin
        unique case (addr)
            A_PEND_LO: rdata = pend[7:0];
            A_OVR_LO:  rdata = ovr[7:0];
            A_MASK_LO: rdata = mask[7:0];
            A_EDGE_LO: rdata = rise_sel[7:0];
            A_HI:      rdata = {2'b00, fields[9:8], rise_sel[8], mask[8], ovr[8], pend[8]};
            A_PRIO:    rdata = fields[7:0];
            A_VEC:     rdata = vector;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/pair_prio_irq_ctrl.sv
module pair_prio_irq_ctrl
    import pic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [8:0]       irq_in,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             ack_valid,
    input  logic [3:0]       ack_index,
    output logic             irq_req,
    output logic [7:0]       vector_out
);
    logic [N_CH-1:0]         pend, ovr, mask, rise_sel, ovr_clr;
    logic [N_PAIR*FLD_W-1:0] fields;
    logic [2:0]              vec_base;
    logic [IDX_W-1:0]        win_idx;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        pic_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .line_in  (irq_in[g]),
            .rise_sel (rise_sel[g]),
            .ack_hit  (ack_valid && (ack_index == IDX_W'(g))),
            .ovr_clr  (ovr_clr[g]),
            .pend     (pend[g]),
            .ovr      (ovr[g])
        );
    end

    pic_arbiter u_arb (
        .req     (pend & mask),
        .fields  (fields),
        .any_req (irq_req),
        .win_idx (win_idx)
    );

    assign vector_out = {vec_base, win_idx, 1'b0};

    pic_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .pend     (pend),
        .ovr      (ovr),
        .vector   (vector_out),
        .mask     (mask),
        .rise_sel (rise_sel),
        .fields   (fields),
        .vec_base (vec_base),
        .ovr_clr  (ovr_clr)
    );

    logic [15:0] req_pad;
    assign req_pad = {7'b0, pend & mask};

    p_vec_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> req_pad[win_idx]);
    p_vec_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (vector_out[4:0] == 5'd0));
endmodule

// File: tb/pair_prio_irq_ctrl_bench.sv
module pair_prio_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] irq_in = '0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       ack_valid = 1'b0;
    logic [3:0] ack_index = '0;
    logic       irq_req;
    logic [7:0] vector_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pair_prio_irq_ctrl u_pair_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ack_valid(ack_valid), .ack_index(ack_index),
        .irq_req(irq_req), .vector_out(vector_out)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(int ch);
        @(negedge clk);
        irq_in[ch] = 1'b1;
        @(negedge clk);
        irq_in[ch] = 1'b0;
    endtask

    task automatic ack(logic [3:0] k);
        @(negedge clk);
        ack_valid = 1'b1; ack_index = k;
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd(3'd0, d); chk("R1 pending", d, 8'h00);
        rd(3'd1, d); chk("R1 overrun", d, 8'h00);
        rd(3'd2, d); chk("R1 mask", d, 8'h00);
        rd(3'd3, d); chk("R1 edge", d, 8'hFF);
        rd(3'd4, d); chk("R1 hi", d, 8'h08);
        rd(3'd5, d); chk("R1 prio", d, 8'h00);
        rd(3'd6, d); chk("R1 vector", d, 8'h00);
        chk("R1 irq_req", {7'b0, irq_req}, 8'h00);
        wr(3'd7, 8'hFF);
        rd(3'd7, d); chk("R12 reg7 reads 0", d, 8'h00);
    endtask

    task automatic t_edge;
        logic [7:0] d;
        wr(3'd2, 8'hFF);
        wr(3'd4, 8'h0E);
        pulse(3);
        rd(3'd0, d); chk("R2 rising sets pending", d, 8'h08);
        chk("R7 irq_req set", {7'b0, irq_req}, 8'h01);
        chk("R8 vector ch3", vector_out, 8'h06);
        ack(3);
        rd(3'd0, d); chk("R9 ack clears", d, 8'h00);
        chk("R7 irq_req cleared", {7'b0, irq_req}, 8'h00);
        wr(3'd3, 8'hFB);
        @(negedge clk); irq_in[2] = 1'b1;
        @(negedge clk);
        rd(3'd0, d); chk("R2 rising ignored on falling select", d, 8'h00);
        irq_in[2] = 1'b0;
        @(negedge clk);
        rd(3'd0, d); chk("R2 falling sets pending", d, 8'h04);
        wr(3'd3, 8'hFF);
        ack(2);
    endtask

    task automatic t_prio;
        wr(3'd5, 8'h18);
        pulse(0); pulse(5); pulse(2);
        chk("R4 highest level F0 wins", vector_out, 8'h04);
        ack(2);
        chk("R4 next G1 wins", vector_out, 8'h0A);
        ack(5);
        chk("R4 then E0", vector_out, 8'h00);
        chk("R4 E0 request", {7'b0, irq_req}, 8'h01);
        ack(0);
        pulse(2); pulse(3);
        chk("R3 odd channel of pair ranks higher", vector_out, 8'h06);
        ack(3);
        chk("R3 even channel remains", vector_out, 8'h04);
        ack(2);
        wr(3'd4, 8'h3E);
        pulse(0); pulse(8);
        chk("R3 I field level 6 wins", vector_out, 8'h10);
        ack(8); ack(0);
        wr(3'd4, 8'h0E);
        wr(3'd5, 8'h00);
    endtask

    task automatic t_tie;
        pulse(7); pulse(1);
        chk("R5 tie to E1 over H1", vector_out, 8'h02);
        ack(1);
        chk("R5 H1 after E1", vector_out, 8'h0E);
        ack(7);
        pulse(8); pulse(0);
        chk("R5 tie to E0 over I0", vector_out, 8'h00);
        ack(0);
        chk("R5 I0 after E0", vector_out, 8'h10);
        ack(8);
    endtask

    task automatic t_mask;
        logic [7:0] d;
        wr(3'd2, 8'hEF);
        pulse(4);
        chk("R6 masked no request", {7'b0, irq_req}, 8'h00);
        rd(3'd0, d); chk("R6 pending kept", d, 8'h10);
        chk("R8 vector empty", vector_out, 8'h00);
        wr(3'd2, 8'hFF);
        chk("R6 unmask raises request", {7'b0, irq_req}, 8'h01);
        chk("R8 vector ch4", vector_out, 8'h08);
        ack(4);
    endtask

    task automatic t_vec;
        wr(3'd6, 8'hFF);
        chk("R8 base only", vector_out, 8'hE0);
        pulse(8);
        chk("R8 base plus I0", vector_out, 8'hF0);
        ack(8);
        wr(3'd6, 8'h00);
    endtask

    task automatic t_ack_noeff;
        logic [7:0] d;
        pulse(1);
        ack(5);
        rd(3'd0, d); chk("R9 ack other channel no effect", d, 8'h02);
        ack(4'd12);
        rd(3'd0, d); chk("R9 ack index 12 no effect", d, 8'h02);
        ack(1);
        rd(3'd0, d); chk("R9 ack own channel clears", d, 8'h00);
    endtask

    task automatic t_ovr;
        logic [7:0] d;
        pulse(0); pulse(0);
        rd(3'd1, d); chk("R10 overrun set", d, 8'h01);
        ack(0);
        rd(3'd0, d); chk("R10 pending cleared by ack", d, 8'h00);
        rd(3'd1, d); chk("R10 overrun survives ack", d, 8'h01);
        wr(3'd1, 8'hFF);
        rd(3'd1, d); chk("R10 write 1 keeps overrun", d, 8'h01);
        wr(3'd1, 8'hFE);
        rd(3'd1, d); chk("R10 write 0 clears overrun", d, 8'h00);
        pulse(8); pulse(8);
        rd(3'd4, d); chk("R10 I0 overrun and pending", d & 8'h03, 8'h03);
        ack(8);
        wr(3'd4, 8'h0C);
        rd(3'd4, d); chk("R10 I0 overrun cleared", d & 8'h03, 8'h00);
    endtask

    task automatic t_simul;
        logic [7:0] d;
        pulse(6);
        @(negedge clk);
        irq_in[6] = 1'b1; ack_valid = 1'b1; ack_index = 4'd6;
        @(negedge clk);
        irq_in[6] = 1'b0; ack_valid = 1'b0;
        rd(3'd0, d); chk("R11 pending stays", d, 8'h40);
        rd(3'd1, d); chk("R11 no overrun", d, 8'h00);
        ack(6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_edge();
        t_prio();
        t_tie();
        t_mask();
        t_vec();
        t_ack_noeff();
        t_ovr();
        t_simul();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule